// File: doc/BRIEF.md
# RISC Integer Execute Unit

This is a purely combinational execute stage for a fixed 32-bit, three-format RISC encoding. It receives one instruction word together with the two source register values already read for it. It returns the computed result, the index of the register that should receive a value, and a write-enable. The register file, data memory and branch handling sit outside it. For memory operations the result is the effective address.

Register-register operations (selected by opcode 0 and the function field) cover add, subtract, AND, OR, signed set-less-than and logical shifts by an immediate amount. Immediate operations extend their 16-bit constant in one of two ways. Arithmetic and address forms sign-extend it. Logical forms zero-extend it. Load-upper places the constant in the high half. Anything the unit does not recognise produces no register write. A write aimed at register 0 is always suppressed.

Top module: `risc_exec_unit`

## Requirements
- R1: Register-register forms use opcode 0 (bits [31:26]). The first source index is in [25:21], the second source index is in [20:16], the destination index is in [15:11], the shift amount is in [10:6] and the function code is in [5:0]. Function 32 is add, which returns `rs_val + rt_val` modulo 2^32, with wr_idx = bits [15:11]. Word 0x00AF8020 yields wr_idx 16 with wr_en high.
- R2: Function 34 returns `rs_val - rt_val` modulo 2^32. Function 36 returns the bitwise AND of the two sources and function 37 returns their bitwise OR. All three write to bits [15:11].
- R3: Function 42 and opcode 10 (immediate form) return 1 when the first source is less than the second operand as two's-complement signed numbers, and 0 otherwise.
- R4: Function 0 shifts `rt_val` left and function 2 shifts it right, both by bits [10:6], with zeros filling the vacated positions. The result goes to bits [15:11].
- R5: Opcode 8 returns `rs_val` plus the sign-extended immediate in bits [15:0], modulo 2^32. Opcode 10 compares against the sign-extended immediate. Both write to bits [20:16].
- R6: Opcode 12 (AND) and opcode 13 (OR) combine `rs_val` with the zero-extended immediate and write to bits [20:16].
- R7: Opcode 15 returns the immediate in bits [31:16] with bits [15:0] cleared, and writes to bits [20:16].
- R8: Opcodes 35 (word load) and 43 (word store) return `rs_val` plus the sign-extended offset. The load raises wr_en with wr_idx = bits [20:16]. The store keeps wr_en low.
- R9: Any opcode other than 0, 8, 10, 12, 13, 15, 35 and 43 keeps wr_en low. So does opcode 0 with a function code outside {0, 2, 32, 34, 36, 37, 42}.
- R10: wr_en is never high while wr_idx is 0. The all-zero word is therefore a no-op with wr_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| result | output | 32 | ALU result or effective address |
| wr_en | output | 1 | Register write request |
| wr_idx | output | 5 | Destination register index |

## Verification
Each operation is driven with operands chosen to separate it from its neighbours. Carries across bit 31 expose missing modulo wrap. Mixed-sign operands tell signed from unsigned comparison. Immediates with bit 15 set tell sign extension from zero extension. A bit pattern spread across all four bytes shows the shift direction and the zero fill. Destination-field checks separate rd from rt routing. Undefined opcodes, undefined function codes and writes to register 0 confirm that write-enable stays low.

// File: rtl/risc_exec_unit.sv
module risc_exec_unit #(
  parameter int XLEN = 32,
  parameter int RIDX = 5,
  parameter int IMMW = 16
) (
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic [XLEN-1:0] result,
  output logic            wr_en,
  output logic [RIDX-1:0] wr_idx
);
  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_SLTI = 6'd10;
  localparam logic [5:0] OP_ANDI = 6'd12;
  localparam logic [5:0] OP_ORI  = 6'd13;
  localparam logic [5:0] OP_LUI  = 6'd15;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SW   = 6'd43;
  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam int PADW = XLEN - IMMW;

  wire [5:0]      op    = instr[31:26];
  wire [5:0]      fn    = instr[5:0];
  wire [4:0]      shamt = instr[10:6];
  wire [RIDX-1:0] rd    = instr[15:11];
  wire [RIDX-1:0] rt    = instr[20:16];
  wire [IMMW-1:0] imm   = instr[15:0];

  wire [XLEN-1:0] imm_sx = {{PADW{imm[IMMW-1]}}, imm};
  wire [XLEN-1:0] imm_zx = {{PADW{1'b0}}, imm};
  wire [XLEN-1:0] addr   = rs_val + imm_sx;

  logic            we;
  logic [RIDX-1:0] dst;

  always_comb begin
    result = '0;
    we     = 1'b0;
    dst    = rt;
    unique case (op)
      OP_REG: begin
        dst = rd;
        we  = 1'b1;
        case (fn)
          FN_ADD:  result = rs_val + rt_val;
          FN_SUB:  result = rs_val - rt_val;
          FN_AND:  result = rs_val & rt_val;
          FN_OR:   result = rs_val | rt_val;
          FN_SLT:  result = {{(XLEN-1){1'b0}}, $signed(rs_val) < $signed(rt_val)};
          FN_SLL:  result = rt_val << shamt;
          FN_SRL:  result = rt_val >> shamt;
          default: we = 1'b0;
        endcase
      end
      OP_ADDI: begin result = addr; we = 1'b1; end
      OP_SLTI: begin
        result = {{(XLEN-1){1'b0}}, $signed(rs_val) < $signed(imm_sx)};
        we = 1'b1;
      end
      OP_ANDI: begin result = rs_val & imm_zx; we = 1'b1; end
      OP_ORI:  begin result = rs_val | imm_zx; we = 1'b1; end
      OP_LUI:  begin result = {imm, {PADW{1'b0}}}; we = 1'b1; end
      OP_LW:   begin result = addr; we = 1'b1; end
      OP_SW:   result = addr;
      default: ;
    endcase
  end

  assign wr_idx = dst;
  assign wr_en  = we && (dst != '0);

  always_comb begin
    // R9
    known_op_chk: assert (!wr_en || op inside {OP_REG, OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_LUI, OP_LW});
    // R10
    zero_dst_chk: assert (!(wr_en && wr_idx == '0));
    // R7
    lui_low_chk: assert (op != OP_LUI || result[PADW-1:0] == '0);
    // R3
    slt_bool_chk: assert (!(op == OP_SLTI || (op == OP_REG && fn == FN_SLT)) || result[XLEN-1:1] == '0);
    // R4
    sll_fill_chk: assert (!(op == OP_REG && fn == FN_SLL) ||
                          (result & ((XLEN'(1) << shamt) - XLEN'(1))) == '0);
    // R8
    sw_nowr_chk: assert (op != OP_SW || !wr_en);
  end
endmodule

// File: tb/test_risc_exec_unit.sv
`timescale 1ns/1ps
module test_risc_exec_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr, rs_val, rt_val, result;
  logic        wr_en;
  logic [4:0]  wr_idx;
  int errors = 0, checks = 0;
  bit done = 0;

  risc_exec_unit i_risc_exec_unit (
    .instr(instr), .rs_val(rs_val), .rt_val(rt_val),
    .result(result), .wr_en(wr_en), .wr_idx(wr_idx)
  );

  function automatic logic [31:0] rw(input int rs, input int rt, input int rd, input int sh, input int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] iw(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = w; rs_val = a; rt_val = b;
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [31:0] r, input logic we, input int idx);
    chk(req, "result", result, r);
    chk(req, "wr_en", {31'd0, wr_en}, {31'd0, we});
    if (we) chk(req, "wr_idx", {27'd0, wr_idx}, 32'(idx));
  endtask

  task automatic t_nop;  // R10
    apply(32'h0, 32'h0, 32'h0);
    chk("R10", "nop wr_en", {31'd0, wr_en}, 32'd0);
    apply(iw(8, 3, 0, 16'd5), 32'd1, 32'd0);
    chk("R10", "addi to r0 wr_en", {31'd0, wr_en}, 32'd0);
    apply(rw(1, 2, 0, 0, 32), 32'd1, 32'd1);
    chk("R10", "add to r0 wr_en", {31'd0, wr_en}, 32'd0);
  endtask

  task automatic t_add;  // R1
    apply(32'h00AF8020, 32'd7, 32'd9);
    chk_out("R1", 32'd16, 1'b1, 16);
    apply(rw(4, 5, 6, 0, 32), 32'hFFFF_FFFF, 32'd2);
    chk_out("R1", 32'd1, 1'b1, 6);
  endtask

  task automatic t_sub_logic;  // R2
    apply(rw(1, 2, 3, 0, 34), 32'd3, 32'd5);
    chk_out("R2", 32'hFFFF_FFFE, 1'b1, 3);
    apply(rw(1, 2, 9, 0, 36), 32'hDF5A48F5, 32'hF0F0F0F0);
    chk_out("R2", 32'hDF5A48F5 & 32'hF0F0F0F0, 1'b1, 9);
    apply(rw(1, 2, 31, 0, 37), 32'h1200_00F0, 32'h0034_000F);
    chk_out("R2", 32'h1234_00FF, 1'b1, 31);
  endtask

  task automatic t_slt;  // R3
    apply(rw(1, 2, 8, 0, 42), 32'hFFFF_FFFF, 32'd1);
    chk_out("R3", 32'd1, 1'b1, 8);
    apply(rw(1, 2, 8, 0, 42), 32'd1, 32'hFFFF_FFFF);
    chk_out("R3", 32'd0, 1'b1, 8);
    apply(rw(1, 2, 8, 0, 42), 32'd77, 32'd77);
    chk_out("R3", 32'd0, 1'b1, 8);
  endtask

  task automatic t_shift;  // R4
    apply(rw(0, 16, 17, 8, 0), 32'h1111_1111, 32'hDF5A48F5);
    chk_out("R4", 32'h5A48F500, 1'b1, 17);
    apply(rw(0, 17, 18, 4, 2), 32'h1111_1111, 32'h5A48F500);
    chk_out("R4", 32'h05A48F50, 1'b1, 18);
    apply(rw(0, 17, 18, 31, 2), 32'h0, 32'h8000_0000);
    chk_out("R4", 32'h1, 1'b1, 18);
    apply(rw(0, 17, 18, 0, 0), 32'h0, 32'hCAFE_F00D);
    chk_out("R4", 32'hCAFE_F00D, 1'b1, 18);
  endtask

  task automatic t_imm_arith;  // R5
    apply(iw(8, 1, 7, 16'hFFFF), 32'd10, 32'h0);
    chk_out("R5", 32'd9, 1'b1, 7);
    apply(iw(10, 1, 7, 16'hFFFD), 32'hFFFF_FFFB, 32'h0);
    chk_out("R5", 32'd1, 1'b1, 7);
    apply(iw(10, 1, 7, 16'h8000), 32'd0, 32'h0);
    chk_out("R5", 32'd0, 1'b1, 7);
  endtask

  task automatic t_imm_logic;  // R6
    apply(iw(12, 1, 11, 16'h8001), 32'hFFFF_FFFF, 32'h0);
    chk_out("R6", 32'h0000_8001, 1'b1, 11);
    apply(iw(13, 1, 11, 16'hFFFF), 32'h0, 32'h0);
    chk_out("R6", 32'h0000_FFFF, 1'b1, 11);
  endtask

  task automatic t_lui;  // R7
    apply(iw(15, 0, 12, 16'hAAAA), 32'h1234_5678, 32'h0);
    chk_out("R7", 32'hAAAA_0000, 1'b1, 12);
  endtask

  task automatic t_mem;  // R8
    apply(iw(35, 8, 9, 16'hFFFC), 32'h0000_1000, 32'h0);
    chk_out("R8", 32'h0000_0FFC, 1'b1, 9);
    apply(iw(35, 8, 9, 16'h7FFF), 32'h0000_1000, 32'h0);
    chk_out("R8", 32'h0000_8FFF, 1'b1, 9);
    apply(iw(43, 8, 9, 16'd32), 32'h0000_2000, 32'h5555_5555);
    chk_out("R8", 32'h0000_2020, 1'b0, 9);
  endtask

  task automatic t_unknown;  // R9
    apply(iw(2, 4, 5, 16'h1234), 32'h1, 32'h2);
    chk("R9", "jump opcode wr_en", {31'd0, wr_en}, 32'd0);
    apply(iw(63, 4, 5, 16'h1234), 32'h1, 32'h2);
    chk("R9", "opcode 63 wr_en", {31'd0, wr_en}, 32'd0);
    apply(rw(4, 5, 6, 0, 1), 32'h1, 32'h2);
    chk("R9", "funct 1 wr_en", {31'd0, wr_en}, 32'd0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    instr = '0; rs_val = '0; rt_val = '0;
    repeat (2) @(negedge clk);
    t_nop();
    t_add();
    t_sub_logic();
    t_slt();
    t_shift();
    t_imm_arith();
    t_imm_logic();
    t_lui();
    t_mem();
    t_unknown();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule